// File: doc/BRIEF.md
# Page Write Controller with Toggle Polling

This block gathers a burst of byte writes that fall on one page of a non-volatile array into a local page buffer. The first accepted write opens the page and fixes its page number (the address bits above the in-page offset). Every later write to the same page is stored at its offset and restarts a byte-load timer. When that timer runs out with no further accepted write, the page is closed and a timed programming phase begins. At the end of that phase a one-cycle commit pulse hands the page number, a per-byte valid mask and the buffered bytes to the array.

While programming is under way the block reports busy. Each read strobe in that phase inverts bit 6 of the status byte, so a host that polls can tell "still programming" (the bit differs between two reads) from "done" (it stops changing). Both time limits are parameters counted in clock cycles.

The controller has three states. IDLE waits for a write; a write moves it to LOAD (transition "open page"). LOAD stays put on each accepted write (transition "reload timer") and moves to PROG when the load timer expires (transition "close page"). PROG returns to IDLE when the programming time has elapsed (transition "commit"), and the commit pulse is raised on that transition.

Top module: `page_write_ctrl`

## Requirements
- R1: While reset is held and right after it, `busy` and `commit_vld` are 0 and `rd_status` is 0.
- R2: A write in IDLE opens a page: its page number `wr_addr[14:7]` is recorded and its byte is stored at offset `wr_addr[6:0]`; `busy` stays 0 during loading.
- R3: `busy` rises exactly LOAD_CYC clock edges after the edge that accepted the last write of the page; each accepted write restarts this count.
- R4: A write during loading whose `wr_addr[14:7]` differs from the open page is dropped. It stores nothing and does not restart the load count.
- R5: `busy` stays 1 for exactly PROG_CYC cycles. On the edge where it falls, `commit_vld` is 1 for one cycle.
- R6: While `commit_vld` is 1, `commit_base` is the page number, `commit_mask` bit i is 1 exactly when offset i was written, and `commit_data[8*i+7:8*i]` holds the byte for offset i.
- R7: When one offset is written more than once in a page, the last data written is the data committed.
- R8: Writes while `busy` is 1 are dropped. They change neither the committed page nor the programming time.
- R9: While `busy` is 1, each read strobe inverts `rd_status` bit 6 on the next edge. All other status bits stay 0.
- R10: Read strobes while `busy` is 0 leave `rd_status` unchanged.
- R11: A page can hold all 128 offsets, and all of them are committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle accepted write strobe |
| wr_addr | input | 15 | Write byte address (page number and offset) |
| wr_data | input | 8 | Write byte |
| rd_stb | input | 1 | One-cycle read strobe |
| busy | output | 1 | Programming phase in progress |
| rd_status | output | 8 | Status byte; bit 6 toggles on reads while busy |
| commit_vld | output | 1 | One-cycle commit pulse |
| commit_base | output | 8 | Page number of the committed page |
| commit_mask | output | 128 | Per-offset byte-valid mask |
| commit_data | output | 1024 | Buffered page bytes, offset i in bits 8i+7:8i |

## Verification
The assertions assume that the strobes are single-cycle pulses sampled on the rising edge and that writes and reads are never issued in the same cycle. The stimulus drives each strobe for exactly one cycle from the falling edge, and never overlaps a read with a write. It also keeps the gap between valid writes of a page below the load limit, so that a page closes only where the bench intends. Foreign-page writes are placed inside those gaps, and reads and writes are placed inside the programming window, so that each dropped access can be seen at the ports.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } pwc_state_e;

endpackage

// File: rtl/pwc_cycle_timer.sv
module pwc_cycle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            count <= '0;
        end else if (count != CNT_MAX) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/pwc_page_buf.sv
module pwc_page_buf #(
    parameter int DATA_W = 8,
    parameter int OFS_W  = 7
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                we,
    input  logic                                clr,
    input  logic [OFS_W-1:0]                    ofs,
    input  logic [DATA_W-1:0]                   din,
    output logic [(1<<OFS_W)-1:0]               mask_o,
    output logic [(1<<OFS_W)*DATA_W-1:0]        data_o
);

    localparam int SLOTS = 1 << OFS_W;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic              hit;
        logic              vld_q;
        logic [DATA_W-1:0] byte_q;

        assign hit = we && (ofs == OFS_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q  <= 1'b0;
                byte_q <= '0;
            end else begin
                if (hit) begin
                    vld_q  <= 1'b1;
                    byte_q <= din;
                end else if (clr) begin
                    vld_q  <= 1'b0;
                end
            end
        end

        assign mask_o[i]                     = vld_q;
        assign data_o[i*DATA_W +: DATA_W]    = byte_q;
    end

endmodule

// File: rtl/pwc_toggle.sv
module pwc_toggle #(
    parameter int DATA_W  = 8,
    parameter int TOG_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] status
);

    logic tog_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
        end else if (busy && rd_stb) begin
            tog_q <= ~tog_q;
        end
    end

    always_comb begin
        status          = '0;
        status[TOG_BIT] = tog_q;
    end

endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl
    import pwc_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int OFS_W    = 7,
    parameter int LOAD_CYC = 5000,
    parameter int PROG_CYC = 250000,
    parameter int TOG_BIT  = 6
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_stb,
    input  logic [ADDR_W-1:0]                    wr_addr,
    input  logic [DATA_W-1:0]                    wr_data,
    input  logic                                 rd_stb,
    output logic                                 busy,
    output logic [DATA_W-1:0]                    rd_status,
    output logic                                 commit_vld,
    output logic [ADDR_W-OFS_W-1:0]              commit_base,
    output logic [(1<<OFS_W)-1:0]                commit_mask,
    output logic [(1<<OFS_W)*DATA_W-1:0]         commit_data
);

    localparam int PAGE_W  = ADDR_W - OFS_W;
    localparam int MAX_CYC = (LOAD_CYC > PROG_CYC) ? LOAD_CYC : PROG_CYC;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] LOAD_LAST = CNT_W'(LOAD_CYC - 1);
    localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_CYC - 1);

    pwc_state_e        state_q, state_d;
    logic [PAGE_W-1:0] base_q;
    logic [PAGE_W-1:0] wr_page;
    logic [OFS_W-1:0]  wr_ofs;
    logic              page_hit;
    logic              accept;
    logic              open_page;
    logic              load_done;
    logic              prog_done;
    logic              tmr_restart;
    logic [CNT_W-1:0]  tmr_cnt;

    assign wr_page  = wr_addr[ADDR_W-1:OFS_W];
    assign wr_ofs   = wr_addr[OFS_W-1:0];
    assign page_hit = (wr_page == base_q);

    // Write acceptance: any write opens a page from IDLE; in LOAD only same-page writes count.
    always_comb begin
        open_page = wr_stb && (state_q == ST_IDLE);
        accept    = open_page || (wr_stb && (state_q == ST_LOAD) && page_hit);
        load_done = (state_q == ST_LOAD) && (tmr_cnt == LOAD_LAST) && !accept;
        prog_done = (state_q == ST_PROG) && (tmr_cnt == PROG_LAST);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (open_page) state_d = ST_LOAD;   // open page
            ST_LOAD: if (load_done) state_d = ST_PROG;   // close page
            ST_PROG: if (prog_done) state_d = ST_IDLE;   // commit
            default: state_d = ST_IDLE;
        endcase
    end

    assign tmr_restart = accept || (state_d != state_q);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs and page number
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q     <= '0;
            commit_vld <= 1'b0;
        end else begin
            if (open_page) begin
                base_q <= wr_page;
            end
            commit_vld <= prog_done;
        end
    end

    assign busy        = (state_q == ST_PROG);
    assign commit_base = base_q;

    pwc_cycle_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .count   (tmr_cnt)
    );

    pwc_page_buf #(
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (accept),
        .clr    (open_page),
        .ofs    (wr_ofs),
        .din    (wr_data),
        .mask_o (commit_mask),
        .data_o (commit_data)
    );

    pwc_toggle #(
        .DATA_W  (DATA_W),
        .TOG_BIT (TOG_BIT)
    ) u_tog (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy   (busy),
        .rd_stb (rd_stb),
        .status (rd_status)
    );

endmodule

// File: rtl/pwc_checker.sv
module pwc_checker #(
    parameter int DATA_W  = 8,
    parameter int OFS_W   = 7,
    parameter int TOG_BIT = 6
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_stb,
    input logic                          rd_stb,
    input logic                          busy,
    input logic [DATA_W-1:0]             rd_status,
    input logic                          commit_vld,
    input logic [(1<<OFS_W)-1:0]         commit_mask,
    input logic [(1<<OFS_W)*DATA_W-1:0]  commit_data
);

    logic [DATA_W-1:0] other_bits;
    always_comb begin
        other_bits          = rd_status;
        other_bits[TOG_BIT] = 1'b0;
    end

    AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_vld |=> !commit_vld);                                     // R5
    AST_COMMIT_AT_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> commit_vld);                                     // R5
    AST_COMMIT_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        commit_vld |-> (commit_mask != '0));                             // R6
    AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_stb) |=> ($stable(commit_mask) && $stable(commit_data))); // R8
    AST_TOGGLE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_stb) |=> (rd_status[TOG_BIT] != $past(rd_status[TOG_BIT]))); // R9
    AST_STATUS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        other_bits == '0);                                               // R9
    AST_IDLE_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(rd_status));                                   // R10

endmodule

bind page_write_ctrl pwc_checker #(
    .DATA_W  (DATA_W),
    .OFS_W   (OFS_W),
    .TOG_BIT (TOG_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_stb      (wr_stb),
    .rd_stb      (rd_stb),
    .busy        (busy),
    .rd_status   (rd_status),
    .commit_vld  (commit_vld),
    .commit_mask (commit_mask),
    .commit_data (commit_data)
);

// File: tb/page_write_ctrl_tb.sv
module page_write_ctrl_tb;

    localparam int LOAD_CYC = 12;
    localparam int PROG_CYC = 30;
    localparam int NB       = 128;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_stb = 1'b0;
    logic [14:0]      wr_addr = '0;
    logic [7:0]       wr_data = '0;
    logic             rd_stb = 1'b0;
    logic             busy;
    logic [7:0]       rd_status;
    logic             commit_vld;
    logic [7:0]       commit_base;
    logic [NB-1:0]    commit_mask;
    logic [NB*8-1:0]  commit_data;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_data [NB];
    logic       m_mask [NB];
    logic       exp_tog = 1'b0;

    always #10 clk = ~clk;

    page_write_ctrl #(
        .LOAD_CYC (LOAD_CYC),
        .PROG_CYC (PROG_CYC)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (wr_stb),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_stb      (rd_stb),
        .busy        (busy),
        .rd_status   (rd_status),
        .commit_vld  (commit_vld),
        .commit_base (commit_base),
        .commit_mask (commit_mask),
        .commit_data (commit_data)
    );

    task automatic chk(input string req, input logic [NB*8-1:0] act, input logic [NB*8-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [NB-1:0] exp_mask_vec();
        logic [NB-1:0] v;
        for (int i = 0; i < NB; i++) v[i] = m_mask[i];
        return v;
    endfunction

    function automatic logic [NB*8-1:0] exp_data_vec();
        logic [NB*8-1:0] v;
        v = '0;
        for (int i = 0; i < NB; i++) if (m_mask[i]) v[i*8 +: 8] = m_data[i];
        return v;
    endfunction

    function automatic logic [NB*8-1:0] masked_dut_data();
        logic [NB*8-1:0] v;
        v = '0;
        for (int i = 0; i < NB; i++) if (commit_mask[i]) v[i*8 +: 8] = commit_data[i*8 +: 8];
        return v;
    endfunction

    function automatic logic [7:0] exp_status();
        return {1'b0, exp_tog, 6'b0};
    endfunction

    task automatic do_write(input logic [14:0] a, input logic [7:0] d);
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic do_read();
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    // mode 0: random offsets, 1: sequential full page, 2: repeated offset
    task automatic run_page(input logic [7:0] base, input int n, input int mode);
        logic [6:0] o;
        logic [7:0] d;
        int r;
        for (int i = 0; i < NB; i++) m_mask[i] = 1'b0;
        for (int k = 0; k < n; k++) begin
            o = (mode == 1) ? 7'(k) : (mode == 2) ? 7'd5 : 7'($urandom_range(0, NB-1));
            d = 8'($urandom);
            do_write({base, o}, d);
            m_mask[o] = 1'b1; m_data[o] = d;   // R7 later data replaces earlier
            chk("R2 not busy while loading", {1023'b0, busy}, '0);
            if (k != n-1) begin
                for (int g = 0; g < int'($urandom_range(0, LOAD_CYC-4)); g++) begin
                    r = int'($urandom_range(0, 3));
                    if (r == 0) begin
                        do_read();
                        chk("R10 idle read holds status", {1016'b0, rd_status}, {1016'b0, exp_status()});
                    end else if (r == 1) begin
                        do_write({base ^ 8'(1 + $urandom_range(0, 254)), 7'($urandom)}, 8'($urandom)); // R4
                    end else begin
                        @(negedge clk);
                    end
                end
            end
        end
        // timing of close page with a foreign write that must not restart the count
        repeat (3) @(negedge clk);
        do_write({base ^ 8'h80, 7'($urandom)}, 8'($urandom));
        repeat (LOAD_CYC - 5) @(negedge clk);
        chk("R3/R4 busy still low one cycle before timeout", {1023'b0, busy}, '0);
        @(negedge clk);
        chk("R3 busy rises after load timeout", {1023'b0, busy}, {1023'b0, 1'b1});
        // programming phase: polling reads and a dropped write
        r = int'($urandom_range(1, 4));
        for (int k = 0; k < r; k++) begin
            do_read();
            exp_tog = ~exp_tog;
            chk("R9 status toggles on busy read", {1016'b0, rd_status}, {1016'b0, exp_status()});
        end
        o = 7'($urandom);
        d = m_mask[o] ? ~m_data[o] : 8'($urandom);
        do_write({base, o}, d);                               // R8 ignored
        repeat (PROG_CYC - r - 2) @(negedge clk);
        chk("R5 busy held through programming", {1022'b0, busy, commit_vld}, {1022'b0, 2'b10});
        @(negedge clk);
        chk("R5 commit pulse as busy falls", {1022'b0, busy, commit_vld}, {1022'b0, 2'b01});
        chk("R6 commit base", {1016'b0, commit_base}, {1016'b0, base});
        chk("R6/R8/R11 commit mask", {896'b0, commit_mask}, {896'b0, exp_mask_vec()});
        chk("R6/R7/R8 commit data", masked_dut_data(), exp_data_vec());
        @(negedge clk);
        chk("R5 commit lasts one cycle", {1023'b0, commit_vld}, '0);
        do_read();
        chk("R10 read after programming holds status", {1016'b0, rd_status}, {1016'b0, exp_status()});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {1014'b0, busy, commit_vld, rd_status}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs after reset", {1014'b0, busy, commit_vld, rd_status}, '0);
        run_page(8'h3C, 1, 0);      // R2 single-byte page
        run_page(8'hA5, NB, 1);     // R11 full page
        run_page(8'h01, 4, 2);      // R7 same offset rewritten
        for (int p = 0; p < 6; p++) run_page(8'($urandom), int'($urandom_range(1, 40)), 0);
        run_page(8'hFF, 2, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule